// File: doc/BRIEF.md
# Blanked, Deglitched Fault Qualifier

This block sits between a fast analog comparator and the shutdown input of a power switch controller. It takes the comparator's raw trip level, which may change at any time relative to the system clock, brings it into the clock domain, and decides whether the trip is a real overcurrent or overvoltage event. Two filters make that decision. The first is a blanking window opened by a strobe marking each switching edge, which hides the transient expected right after that edge. The second is a duration filter: the trip must stay high without a break for a programmed number of cycles.

Once a trip qualifies, a retriggerable stretcher drives the fault output for at least a programmed number of cycles, so a receiver with a minimum pulse-width requirement never misses it. The fault stays asserted for as long as the trip stays qualified, even past the stretch time. The output's active level is selectable at run time. A one-cycle marker is raised at the start of each qualification for a downstream latch or retry controller. The three cycle counts can be changed through configuration inputs, and a count of zero bypasses its stage.

Top module: `fault_qualifier`

## Requirements
- R1: With blanking and deglitch both at zero, a trip held high on the input for cycle a shows as an active fault output from cycle a+3 onward: two synchronizer stages and one output register.
- R2: A trip qualifies only after its synchronized level has been high for cfg_deglitch_cycles+1 consecutive cycles, so the fault output rises cfg_deglitch_cycles cycles later than in R1; a trip high for fewer cycles produces no fault.
- R3: A single low synchronized sample restarts the duration count from zero, so two bursts separated by a gap never add up toward qualification.
- R4: A strobe in cycle s with blank length L > 0 hides the synchronized trip during cycles s through s+L-1; a trip that ends inside that range produces no fault and no marker.
- R5: A trip that is still high when the window closes is qualified as usual, starting from the first unblanked cycle: with zero deglitch the fault becomes visible in cycle s+L+1.
- R6: A strobe that arrives while a window is open restarts the window at its full length, counted from the new strobe.
- R7: A blank length of zero or a deglitch length of zero turns that stage into a pass-through.
- R8: A qualified trip produces a fault of max(cfg_stretch_cycles, 1) cycles at least; when the trip stays qualified for longer, the fault lasts as long as the trip does, giving a width of max(run length − deglitch length, stretch length, 1) cycles.
- R9: A new qualification during a running stretch reloads the stretch timer to its full length.
- R10: With cfg_active_high = 1, the active fault level is 1; with cfg_active_high = 0, it is 0 and the idle level is 1.
- R11: qual_pulse is high for exactly one cycle per qualification, in the first cycle of the active fault output.
- R12: During and right after reset, the fault output is at its idle level and qual_pulse is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trip_raw | input | 1 | Comparator trip level, asynchronous |
| sw_edge | input | 1 | Switching-edge strobe, synchronous, one cycle per edge |
| cfg_blank_cycles | input | CNT_W | Blanking window length in cycles, 0 = no blanking |
| cfg_deglitch_cycles | input | CNT_W | Extra cycles a trip must persist, 0 = no deglitch |
| cfg_stretch_cycles | input | CNT_W | Minimum fault width in cycles |
| cfg_active_high | input | 1 | 1: fault output active high, 0: active low |
| fault_out | output | 1 | Qualified, stretched fault at the selected polarity |
| qual_pulse | output | 1 | One-cycle marker of each new qualification |

## Verification
The duration filter is swept over every combination of a small deglitch length, trip burst length and stretch length, so it can be seen where each burst qualifies or falls short, and whether the output width comes from the stretcher or from the trip's own length. A second sweep runs every blank length against every burst length that starts on the strobe: bursts absorbed by the window are separated from bursts that the window only delays. Directed patterns cover a gapped burst that must not add up, a second strobe inside an open window, two narrow trips that overlap in one stretch, and the inverted output level.

// File: rtl/fq_pkg.sv
// Package: shared defaults and the output polarity encoding for the fault
// qualifier. Assumes every counter in the path uses the same width.
package fq_pkg;

    // Default width of all programmable cycle counts.
    localparam int unsigned FQ_CNT_W_DEF = 8;

    // Default depth of the input synchronizer.
    localparam int unsigned FQ_SYNC_DEF = 2;

    // Active level selection for the fault output.
    typedef enum logic {
        FQ_ACT_LOW  = 1'b0,
        FQ_ACT_HIGH = 1'b1
    } fq_pol_e;

    // Remaining cycles after the first one of a window of length len.
    function automatic logic [31:0] fq_tail(input logic [31:0] len);
        return (len == 32'd0) ? 32'd0 : len - 32'd1;
    endfunction

endpackage

// File: rtl/fq_sync.sv
// Module: multi-stage synchronizer for the raw comparator trip.
// Assumes the input can change at any time; adds STAGES cycles of latency.
// STAGES must be at least 2.
module fq_sync #(
    parameter int unsigned STAGES = fq_pkg::FQ_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/fq_blank_window.sv
// Module: leading-edge blanking. A strobe opens a window of len cycles that
// includes the strobe cycle; the trip is masked while the window is open.
// A strobe inside an open window restarts it. len = 0 disables masking.
// Assumes the strobe is synchronous to clk.
module fq_blank_window #(
    parameter int unsigned CNT_W = fq_pkg::FQ_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CNT_W-1:0] len,
    input  logic             trip_in,
    output logic             trip_out,
    output logic             blank_active
);

    logic [CNT_W-1:0] remain;
    logic             open_now;

    // A strobe with a non-zero length starts (or restarts) the window.
    assign open_now = strobe && (len != '0);

    // Count the cycles left in the window after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (open_now) begin
            remain <= CNT_W'(fq_pkg::fq_tail(32'(len)));
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // The window covers the strobe cycle and the remaining count.
    assign blank_active = open_now || (remain != '0);

    // Mask the trip while blanked.
    assign trip_out = trip_in && !blank_active;

    // R6: a strobe reloads the window to the full length.
    a_r6_window_reload: assert property (@(posedge clk) disable iff (!rst_n)
        open_now |=> (remain == $past(len) - 1'b1));

    // R4: an open window without a new strobe shrinks by one each cycle.
    a_r4_window_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_now && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/fq_deglitch.sv
// Module: minimum-duration filter. Counts consecutive high cycles of the
// masked trip; the trip qualifies once the count of earlier high cycles
// reaches tmin. Any low cycle clears the count. tmin = 0 passes the level.
// Assumes tmin does not exceed the saturating count range.
module fq_deglitch #(
    parameter int unsigned CNT_W = fq_pkg::FQ_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_in,
    input  logic [CNT_W-1:0] tmin,
    output logic             qual_lvl
);

    logic [CNT_W-1:0] run_len;

    // Count consecutive high cycles, saturating, cleared by any low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!trip_in) begin
            run_len <= '0;
        end else if (run_len != '1) begin
            run_len <= run_len + 1'b1;
        end
    end

    // Qualified when high now and high for tmin cycles before.
    assign qual_lvl = trip_in && (run_len >= tmin);

    // R3: a low sample restarts the duration count.
    a_r3_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_in |=> (run_len == '0));

    // R2: an uninterrupted trip advances the count by one per cycle.
    a_r2_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_in && run_len != '1) |=> (run_len == $past(run_len) + 1'b1));

endmodule

// File: rtl/fq_stretch.sv
// Module: retriggerable minimum-width stretcher. Each rising edge of the
// qualified level loads a timer so the fault lasts at least pw_min cycles
// (at least one when pw_min = 0); the fault also holds while the level holds.
// Outputs are registered; qual_pulse marks the first fault cycle.
module fq_stretch #(
    parameter int unsigned CNT_W = fq_pkg::FQ_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_lvl,
    input  logic [CNT_W-1:0] pw_min,
    output logic             fault_q,
    output logic             qual_pulse_q
);

    logic             qual_prev;
    logic             qual_rise;
    logic [CNT_W-1:0] hold_left;

    assign qual_rise = qual_lvl && !qual_prev;

    // Track the previous qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_prev <= 1'b0;
        end else begin
            qual_prev <= qual_lvl;
        end
    end

    // Load the stretch timer on each new qualification, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_left <= '0;
        end else if (qual_rise) begin
            hold_left <= CNT_W'(fq_pkg::fq_tail(32'(pw_min)));
        end else if (hold_left != '0) begin
            hold_left <= hold_left - 1'b1;
        end
    end

    // Register the fault level and the qualification marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q      <= 1'b0;
            qual_pulse_q <= 1'b0;
        end else begin
            fault_q      <= qual_lvl || (hold_left != '0);
            qual_pulse_q <= qual_rise;
        end
    end

    // R8: with a stretch of two or more, a rising fault stays up next cycle.
    a_r8_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_q) && pw_min >= CNT_W'(2)) |=> fault_q);

    // R9: a new qualification reloads the full stretch length.
    a_r9_stretch_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_rise && pw_min != '0) |=> (hold_left == $past(pw_min) - 1'b1));

    // R11: the marker lasts one cycle.
    a_r11_marker_single: assert property (@(posedge clk) disable iff (!rst_n)
        qual_pulse_q |=> !qual_pulse_q);

    // R11: the marker coincides with an active fault.
    a_r11_marker_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        qual_pulse_q |-> fault_q);

endmodule

// File: rtl/fault_qualifier.sv
// Module: top of the fault qualification path:
// synchronizer -> blanking window -> duration filter -> stretcher -> polarity.
// Assumes sw_edge and the cfg_* inputs are synchronous to clk; trip_raw may
// be asynchronous. Reset is synchronous and active low.
module fault_qualifier #(
    parameter int unsigned CNT_W       = fq_pkg::FQ_CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = fq_pkg::FQ_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_raw,
    input  logic             sw_edge,
    input  logic [CNT_W-1:0] cfg_blank_cycles,
    input  logic [CNT_W-1:0] cfg_deglitch_cycles,
    input  logic [CNT_W-1:0] cfg_stretch_cycles,
    input  logic             cfg_active_high,
    output logic             fault_out,
    output logic             qual_pulse
);

    logic trip_sync;
    logic trip_unblanked;
    logic blank_on;
    logic trip_qualified;
    logic fault_lvl;

    fq_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trip_raw),
        .sync_out (trip_sync)
    );

    fq_blank_window #(
        .CNT_W        (CNT_W)
    ) u_blank (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (sw_edge),
        .len          (cfg_blank_cycles),
        .trip_in      (trip_sync),
        .trip_out     (trip_unblanked),
        .blank_active (blank_on)
    );

    fq_deglitch #(
        .CNT_W    (CNT_W)
    ) u_deglitch (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_in  (trip_unblanked),
        .tmin     (cfg_deglitch_cycles),
        .qual_lvl (trip_qualified)
    );

    fq_stretch #(
        .CNT_W        (CNT_W)
    ) u_stretch (
        .clk          (clk),
        .rst_n        (rst_n),
        .qual_lvl     (trip_qualified),
        .pw_min       (cfg_stretch_cycles),
        .fault_q      (fault_lvl),
        .qual_pulse_q (qual_pulse)
    );

    // Map the internal active-high fault onto the receiver's level.
    assign fault_out = (cfg_active_high == fq_pkg::FQ_ACT_HIGH) ? fault_lvl : !fault_lvl;

    // R4: nothing passes the filters while the blanking window is open.
    a_r4_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
        blank_on |-> !trip_qualified);

    // R12: the cycle after reset the marker is low.
    a_r12_reset_marker: assert property (@(posedge clk)
        !rst_n |=> !qual_pulse);

endmodule

// File: tb/test_fault_qualifier.sv
module test_fault_qualifier;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trip_raw = 1'b0;
    logic             sw_edge = 1'b0;
    logic [CNT_W-1:0] cfg_blank_cycles = '0;
    logic [CNT_W-1:0] cfg_deglitch_cycles = '0;
    logic [CNT_W-1:0] cfg_stretch_cycles = '0;
    logic             cfg_active_high = 1'b1;
    logic             fault_out;
    logic             qual_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Results of the most recent case.
    int first_on;
    int hi_count;
    int q_count;
    int q_stray;
    int idle_bad;

    always #2 clk = ~clk;

    fault_qualifier #(.CNT_W(CNT_W)) i_fault_qualifier (
        .clk                 (clk),
        .rst_n               (rst_n),
        .trip_raw            (trip_raw),
        .sw_edge             (sw_edge),
        .cfg_blank_cycles    (cfg_blank_cycles),
        .cfg_deglitch_cycles (cfg_deglitch_cycles),
        .cfg_stretch_cycles  (cfg_stretch_cycles),
        .cfg_active_high     (cfg_active_high),
        .fault_out           (fault_out),
        .qual_pulse          (qual_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one case: trip bursts [a, a+w) and [a2, a2+w2), strobes at s and s2.
    // At each falling edge: sample the output of cycle i, then drive cycle i.
    task automatic run_case(input int a, input int w, input int a2, input int w2,
                            input int s, input int s2, input int ncyc);
        first_on = -1;
        hi_count = 0;
        q_count  = 0;
        q_stray  = 0;
        idle_bad = 0;
        for (int i = 0; i < ncyc; i++) begin
            bit act;
            @(negedge clk);
            act = cfg_active_high ? fault_out : !fault_out;
            if (act) begin
                hi_count++;
                if (first_on < 0) first_on = i;
            end
            if (qual_pulse) begin
                q_count++;
                if (!act) q_stray++;
                if (first_on != i && q_count == 1) q_stray++;
            end
            if (i == 0 && act) idle_bad++;
            trip_raw = ((i >= a) && (i < a + w)) || ((i >= a2) && (i < a2 + w2));
            sw_edge  = (i == s) || (i == s2);
        end
        trip_raw = 1'b0;
        sw_edge  = 1'b0;
    endtask

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(fault_out == 1'b0, "R12 fault idle in reset", fault_out, 0);
        chk(qual_pulse == 1'b0, "R12 marker low in reset", qual_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_out == 1'b0, "R12 fault idle after reset", fault_out, 0);
        chk(qual_pulse == 1'b0, "R12 marker low after reset", qual_pulse, 0);

        // R1 R2 R7 R8 R11: deglitch x burst x stretch sweep, no blanking
        for (int tm = 0; tm <= 4; tm++) begin
            for (int w = 1; w <= 8; w++) begin
                for (int pw = 0; pw <= 3; pw++) begin
                    bit hit;
                    cfg_deglitch_cycles = CNT_W'(tm);
                    cfg_stretch_cycles  = CNT_W'(pw);
                    cfg_blank_cycles    = '0;
                    run_case(4, w, 0, 0, -1, -1, 40);
                    hit = (w > tm);
                    if (hit) begin
                        chk(first_on == 4 + 3 + tm, "R1 R2 R7 fault start cycle", first_on, 7 + tm);
                        chk(hi_count == imax(w - tm, imax(pw, 1)), "R8 fault width", hi_count,
                            imax(w - tm, imax(pw, 1)));
                        chk(q_count == 1 && q_stray == 0, "R11 one marker at fault start", q_count, 1);
                    end else begin
                        chk(first_on == -1, "R2 short burst rejected", first_on, -1);
                        chk(q_count == 0, "R2 no marker for short burst", q_count, 0);
                    end
                end
            end
        end

        // R3: gapped bursts 3+3 with deglitch 3 never qualify
        cfg_deglitch_cycles = CNT_W'(3);
        cfg_stretch_cycles  = CNT_W'(1);
        run_case(4, 3, 8, 3, -1, -1, 40);
        chk(first_on == -1, "R3 gap restarts count", first_on, -1);
        chk(q_count == 0, "R3 no marker after gap", q_count, 0);
        // R3: second burst of 4 qualifies alone, counted from its own start
        run_case(4, 3, 8, 4, -1, -1, 40);
        chk(first_on == 8 + 3 + 3, "R3 count from second burst", first_on, 14);
        chk(hi_count == 1, "R3 width after restart", hi_count, 1);

        // R4 R5 R7: blank length x burst sweep, burst aligned to the strobe
        cfg_deglitch_cycles = '0;
        cfg_stretch_cycles  = CNT_W'(1);
        for (int bl = 0; bl <= 5; bl++) begin
            for (int w = 1; w <= 8; w++) begin
                cfg_blank_cycles = CNT_W'(bl);
                run_case(4, w, 0, 0, 6, -1, 40);
                if (w > bl) begin
                    chk(first_on == 6 + bl + 1, "R5 R7 delayed fault start", first_on, 7 + bl);
                    chk(hi_count == w - bl, "R5 delayed fault width", hi_count, w - bl);
                    chk(q_count == 1, "R5 one marker", q_count, 1);
                end else begin
                    chk(first_on == -1, "R4 burst hidden by window", first_on, -1);
                    chk(q_count == 0, "R4 no marker in window", q_count, 0);
                end
            end
        end

        // R6: second strobe inside an open window restarts it
        cfg_blank_cycles = CNT_W'(4);
        run_case(4, 12, 0, 0, 6, 8, 40);
        chk(first_on == 13, "R6 window restarted", first_on, 13);
        chk(hi_count == 6, "R6 width after restart", hi_count, 6);

        // R9: two narrow trips inside one stretch reload the timer
        cfg_blank_cycles   = '0;
        cfg_stretch_cycles = CNT_W'(6);
        run_case(4, 1, 7, 1, -1, -1, 40);
        chk(first_on == 7, "R9 first fault start", first_on, 7);
        chk(hi_count == 9, "R9 reloaded width", hi_count, 9);
        chk(q_count == 2, "R9 two markers", q_count, 2);

        // R10: active-low output
        cfg_active_high     = 1'b0;
        cfg_deglitch_cycles = CNT_W'(1);
        cfg_stretch_cycles  = CNT_W'(2);
        @(negedge clk);
        chk(fault_out == 1'b1, "R10 idle level high when active low", fault_out, 1);
        run_case(4, 5, 0, 0, -1, -1, 40);
        chk(idle_bad == 0, "R10 idle before trip", idle_bad, 0);
        chk(first_on == 8, "R10 inverted fault start", first_on, 8);
        chk(hi_count == 4, "R10 inverted fault width", hi_count, 4);
        chk(fault_out == 1'b1, "R10 back to idle high", fault_out, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule